// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling Converter Sequencer

This block holds the digital timing of a two-channel converter whose channels are sampled at the same instant. It runs on a fast system clock and sees the convert-start strobe and the serial clock as synchronous level inputs. It finds their edges by comparing each input with its value one system clock earlier. The conversion results come from a stub converter as two parallel words. A rising edge on the convert strobe captures both words at once, puts both channels into hold and restarts the output frame. Each later serial-clock rising edge moves the frame forward by one slot.

A frame is 32 serial-clock slots. Channel 0 fills the first 16 slots and channel 1 the last 16. Each channel's word goes out MSB first and is followed by padding slots, and the serial line is enabled only on data slots. The words sent in a frame are the ones captured at the previous convert edge. The block also counts convert pulses that arrive while the serial clock is idle and reports two low-power states from that count.

Top module: `dual_sample_seq`

## Requirements
- R1: After reset, sdo_oe_o=0, sdo_o=0, hold_o=00, samp_o=11, nap_o=0 and sleep_o=0. The frame counter starts idle.
- R2: In the system clock that detects a conv_i rising edge, both ch0_res_i and ch1_res_i are captured. From the next system clock, both bits of hold_o are 1, both bits of samp_o are 0 and the serial output is disabled.
- R3: After the k-th sck_i rising edge that follows a convert edge (k = 1..32), slot s=k-1 is presented. Slots 0..15 carry channel 0 and slots 16..31 carry channel 1. At in-channel position p = s mod 16 with p < RES_BITS, sdo_oe_o=1 and sdo_o is bit RES_BITS-1-p of that channel's word.
- R4: The words sent in a frame are the ones captured at the previous convert edge. The first frame after reset sends zeros.
- R5: sdo_oe_o=0 and sdo_o=0 before the first sck_i rise of a frame, in every padding slot (p >= RES_BITS), and after the 32nd rise. Further sck_i rises do not start a new frame.
- R6: hold_o stays 11 until the 32nd sck_i rise of a frame. After that rise, samp_o=11 and hold_o=00 until the next convert edge.
- R7: If conv_i and sck_i rise in the same system clock, that sck_i rise is not counted, so all frame data appear one serial clock later.
- R8: A convert edge in the middle of a frame restarts the frame at slot zero with the newly shifted word pair.
- R9: Exactly two or three convert rises with no sck_i edge in between set nap_o=1.
- R10: A fourth and any further convert rise with no sck_i edge sets sleep_o=1 and nap_o=0. nap_o and sleep_o are never both 1.
- R11: Any sck_i edge, rising or falling, clears nap_o, sleep_o and the pulse count on the next system clock. A convert rise in the same clock as an sck_i edge is not counted.
- R12: RES_BITS may only be 12 or 14; any other value stops elaboration. At 12 bits each channel has four padding slots, and at 14 bits it has two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_i | input | 1 | Convert-start level, synchronous to clk |
| sck_i | input | 1 | Serial clock level, synchronous to clk |
| ch0_res_i | input | RES_BITS | Channel 0 result from the converter stub |
| ch1_res_i | input | RES_BITS | Channel 1 result from the converter stub |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data drive enable (0 = high impedance) |
| hold_o | output | 2 | Per-channel hold strobe |
| samp_o | output | 2 | Per-channel sample (acquire) strobe |
| nap_o | output | 1 | Nap state flag |
| sleep_o | output | 1 | Sleep state flag |

## Verification
The assertions assume that conv_i and sck_i change between clock edges and are already synchronous, so that a rise seen at one edge is the same rise the block's edge detectors see. They also assume that conv_i is low when reset is released. The bench drives every input on the falling edge of the system clock and samples outputs one falling edge after the rising edge that acts on them. It starts each scenario with both strobes low.

// File: rtl/dss_pkg.sv
package dss_pkg;
   localparam int NCH          = 2;
   localparam int FRAME_SLOTS  = 32;
   localparam int SLOT_PER_CH  = FRAME_SLOTS / NCH;
   localparam int CNT_W        = $clog2(FRAME_SLOTS + 1);
   localparam int POS_W        = $clog2(SLOT_PER_CH);
   localparam int CH_W         = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int NAP_PULSES   = 2;
   localparam int SLEEP_PULSES = 4;
   localparam int PC_W         = $clog2(SLEEP_PULSES + 1);
   typedef logic [CNT_W-1:0] slot_t;
endpackage

// File: rtl/dss_edge.sv
module dss_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o,
   output logic any_o
);
   logic d_q;
   always_ff @(posedge clk) begin
      if (!rst_n) d_q <= 1'b0;
      else        d_q <= d_i;
   end
   assign rise_o = d_i & ~d_q;
   assign any_o  = d_i ^ d_q;
endmodule

// File: rtl/dss_frame.sv
module dss_frame
   import dss_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  conv_rise_i,
   input  logic  sck_rise_i,
   output slot_t slot_cnt_o,
   output logic  busy_o
);
   localparam slot_t LAST = slot_t'(FRAME_SLOTS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_cnt_o <= LAST;
         busy_o     <= 1'b0;
      end else if (conv_rise_i) begin
         slot_cnt_o <= '0;
         busy_o     <= 1'b1;
      end else if (sck_rise_i && slot_cnt_o < LAST) begin
         slot_cnt_o <= slot_cnt_o + slot_t'(1);
         if (slot_cnt_o == LAST - slot_t'(1)) busy_o <= 1'b0;
      end
   end
endmodule

// File: rtl/dss_serial.sv
module dss_serial
   import dss_pkg::*;
#(
   parameter int RES_BITS = 14
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         conv_rise_i,
   input  logic [NCH-1:0][RES_BITS-1:0] res_i,
   input  slot_t                        slot_cnt_i,
   output logic                         sdo_o,
   output logic                         oe_o
);
   logic [RES_BITS-1:0] cur_q [NCH];
   logic [RES_BITS-1:0] out_q [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cur_q[g] <= '0;
            out_q[g] <= '0;
         end else if (conv_rise_i) begin
            out_q[g] <= cur_q[g];
            cur_q[g] <= res_i[g];
         end
      end
   end

   slot_t            s;
   logic [CH_W-1:0]  ch_sel;
   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] bidx;

   always_comb begin
      oe_o   = 1'b0;
      sdo_o  = 1'b0;
      s      = slot_cnt_i - slot_t'(1);
      ch_sel = CH_W'(int'(s) / SLOT_PER_CH);
      pos    = POS_W'(int'(s) % SLOT_PER_CH);
      bidx   = POS_W'(RES_BITS - 1) - pos;
      if (slot_cnt_i != '0 && slot_cnt_i <= slot_t'(FRAME_SLOTS)) begin
         if (pos < POS_W'(RES_BITS)) begin
            oe_o  = 1'b1;
            sdo_o = out_q[ch_sel][bidx];
         end
      end
   end
endmodule

// File: rtl/dss_power.sv
module dss_power
   import dss_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic conv_rise_i,
   input  logic sck_edge_i,
   output logic nap_o,
   output logic sleep_o
);
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_n;

   always_comb begin
      pc_n = (pc_q >= PC_W'(SLEEP_PULSES)) ? pc_q : pc_q + PC_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || sck_edge_i) begin
         pc_q    <= '0;
         nap_o   <= 1'b0;
         sleep_o <= 1'b0;
      end else if (conv_rise_i) begin
         pc_q    <= pc_n;
         sleep_o <= pc_n >= PC_W'(SLEEP_PULSES);
         nap_o   <= pc_n >= PC_W'(NAP_PULSES) && pc_n < PC_W'(SLEEP_PULSES);
      end
   end
endmodule

// File: rtl/dual_sample_seq.sv
module dual_sample_seq
   import dss_pkg::*;
#(
   parameter int RES_BITS = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_i,
   input  logic                sck_i,
   input  logic [RES_BITS-1:0] ch0_res_i,
   input  logic [RES_BITS-1:0] ch1_res_i,
   output logic                sdo_o,
   output logic                sdo_oe_o,
   output logic [NCH-1:0]      hold_o,
   output logic [NCH-1:0]      samp_o,
   output logic                nap_o,
   output logic                sleep_o
);
   if (!(RES_BITS == 12 || RES_BITS == 14)) begin : g_bad_res
      $error("dual_sample_seq: RES_BITS must be 12 or 14");
   end
   if (RES_BITS > SLOT_PER_CH) begin : g_bad_fit
      $error("dual_sample_seq: word does not fit a channel slot group");
   end

   logic  conv_rise, conv_any;
   logic  sck_rise, sck_any;
   slot_t slot_cnt;
   logic  busy;
   logic [NCH-1:0][RES_BITS-1:0] res_bus;

   assign res_bus = {ch1_res_i, ch0_res_i};

   dss_edge u_conv_edge (.clk(clk), .rst_n(rst_n), .d_i(conv_i),
                         .rise_o(conv_rise), .any_o(conv_any));
   dss_edge u_sck_edge  (.clk(clk), .rst_n(rst_n), .d_i(sck_i),
                         .rise_o(sck_rise), .any_o(sck_any));

   dss_frame u_frame (.clk(clk), .rst_n(rst_n), .conv_rise_i(conv_rise),
                      .sck_rise_i(sck_rise), .slot_cnt_o(slot_cnt), .busy_o(busy));

   dss_serial #(.RES_BITS(RES_BITS)) u_serial (
      .clk(clk), .rst_n(rst_n), .conv_rise_i(conv_rise), .res_i(res_bus),
      .slot_cnt_i(slot_cnt), .sdo_o(sdo_o), .oe_o(sdo_oe_o));

   dss_power u_power (.clk(clk), .rst_n(rst_n), .conv_rise_i(conv_rise),
                      .sck_edge_i(sck_any), .nap_o(nap_o), .sleep_o(sleep_o));

   assign hold_o = {NCH{busy}};
   assign samp_o = ~hold_o;

   logic unused_conv_any;
   assign unused_conv_any = conv_any;
endmodule

// File: rtl/dss_chk.sv
module dss_chk
   import dss_pkg::*;
(
   input logic           clk,
   input logic           rst_n,
   input logic           conv_i,
   input logic           sck_i,
   input logic           sdo_o,
   input logic           sdo_oe_o,
   input logic [NCH-1:0] hold_o,
   input logic [NCH-1:0] samp_o,
   input logic           nap_o,
   input logic           sleep_o
);
   // R2
   conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_i) |=> (hold_o == {NCH{1'b1}}) && (samp_o == '0) && !sdo_oe_o);
   // R5
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> !sdo_o);
   // R6
   drive_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe_o |-> hold_o == {NCH{1'b1}});
   // R10
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nap_o && sleep_o));
   // R11
   sck_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sck_i) |=> !nap_o && !sleep_o);
endmodule

bind dual_sample_seq dss_chk u_chk (
   .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .sck_i(sck_i),
   .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .hold_o(hold_o), .samp_o(samp_o),
   .nap_o(nap_o), .sleep_o(sleep_o));

// File: tb/dual_sample_seq_bench.sv
`timescale 1ns/1ps
module dual_sample_seq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv = 1'b0;
   logic sck = 1'b0;
   logic [13:0] d0 = '0, d1 = '0;
   logic sdo_a, oe_a, nap_a, slp_a, sdo_b, oe_b, nap_b, slp_b;
   logic [1:0] hold_a, samp_a, hold_b, samp_b;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [13:0] exp_cur [2];
   logic [13:0] exp_out [2];

   always #2.5 clk = ~clk;

   dual_sample_seq #(.RES_BITS(14)) u_dual_sample_seq (
      .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck),
      .ch0_res_i(d0), .ch1_res_i(d1), .sdo_o(sdo_a), .sdo_oe_o(oe_a),
      .hold_o(hold_a), .samp_o(samp_a), .nap_o(nap_a), .sleep_o(slp_a));

   dual_sample_seq #(.RES_BITS(12)) u_dual_sample_seq_12 (
      .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck),
      .ch0_res_i(d0[11:0]), .ch1_res_i(d1[11:0]), .sdo_o(sdo_b), .sdo_oe_o(oe_b),
      .hold_o(hold_b), .samp_o(samp_b), .nap_o(nap_b), .sleep_o(slp_b));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one convert pulse, sck untouched; model shifts words
   task automatic conv_pulse(input logic [13:0] a, input logic [13:0] b);
      d0 = a; d1 = b; conv = 1'b1;
      exp_out = exp_cur; exp_cur[0] = a; exp_cur[1] = b;
      @(negedge clk);
      chk("R2", "hold after convert", int'(hold_a), 3);
      chk("R2", "samp after convert", int'(samp_a), 0);
      conv = 1'b0;
      @(negedge clk);
   endtask

   task automatic sck_rise();
      sck = 1'b1; @(negedge clk);
   endtask
   task automatic sck_fall();
      sck = 1'b0; @(negedge clk);
   endtask

   // expected slot contents for resolution r
   task automatic slot_check(input int s, input int r, input logic oe, input logic sdo);
      int p, c;
      logic e_oe, e_sdo;
      p = s % 16; c = s / 16;
      e_oe = (p < r); e_sdo = e_oe ? exp_out[c][r-1-p] : 1'b0;
      if (r == 14) begin
         chk(e_oe ? "R3" : "R5", $sformatf("oe14 slot %0d", s), int'(oe), int'(e_oe));
         chk("R4", $sformatf("sdo14 slot %0d", s), int'(sdo), int'(e_sdo));
      end else begin
         chk("R12", $sformatf("oe12 slot %0d", s), int'(oe), int'(e_oe));
         chk("R12", $sformatf("sdo12 slot %0d", s), int'(sdo), int'(e_sdo));
      end
   endtask

   // full 32-slot frame, starting from sck low after a convert
   task automatic run_frame();
      chk("R5", "oe before first sck", int'(oe_a), 0);
      for (int k = 1; k <= 32; k++) begin
         sck_rise();
         slot_check(k - 1, 14, oe_a, sdo_a);
         slot_check(k - 1, 12, oe_b, sdo_b);
         if (k == 31) chk("R6", "hold before last slot", int'(hold_a), 3);
         if (k == 32) begin
            chk("R6", "hold after 32nd", int'(hold_a), 0);
            chk("R6", "samp after 32nd", int'(samp_a), 3);
         end
         sck_fall();
      end
      sck_rise();
      chk("R5", "oe after frame end", int'(oe_a), 0);
      chk("R5", "sdo after frame end", int'(sdo_a), 0);
      chk("R6", "samp stays", int'(samp_a), 3);
      sck_fall();
   endtask

   task automatic t_reset();
      chk("R1", "oe", int'(oe_a), 0);
      chk("R1", "sdo", int'(sdo_a), 0);
      chk("R1", "hold", int'(hold_a), 0);
      chk("R1", "samp", int'(samp_a), 3);
      chk("R1", "nap", int'(nap_a), 0);
      chk("R1", "sleep", int'(slp_a), 0);
   endtask

   task automatic t_frames();
      conv_pulse(14'h2A5C, 14'h1337);
      run_frame();   // zeros from reset (R4)
      conv_pulse(14'h3FFF, 14'h0001);
      run_frame();   // shows 2A5C / 1337
      conv_pulse(14'h0000, 14'h2AAA);
      run_frame();   // shows 3FFF / 0001
   endtask

   task automatic t_late_conv();
      conv_pulse(14'h15F0, 14'h0ACE);
      for (int k = 0; k < 5; k++) begin sck_rise(); sck_fall(); end
      // R7 R8: convert and sck rise in the same clock, mid-frame
      d0 = 14'h3210; d1 = 14'h0123;
      exp_out = exp_cur; exp_cur[0] = d0; exp_cur[1] = d1;
      conv = 1'b1; sck = 1'b1;
      @(negedge clk);
      chk("R7", "oe after coincident edge", int'(oe_a), 0);
      chk("R8", "hold after restart", int'(hold_a), 3);
      conv = 1'b0; sck = 1'b0;
      @(negedge clk);
      run_frame();
   endtask

   task automatic t_power();
      conv_pulse(14'h0011, 14'h0022);
      chk("R9", "nap after one pulse", int'(nap_a), 0);
      conv_pulse(14'h0033, 14'h0044);
      chk("R9", "nap after two pulses", int'(nap_a), 1);
      chk("R9", "sleep after two pulses", int'(slp_a), 0);
      // R11: coincident convert + sck rise clears and is not counted
      conv = 1'b1; sck = 1'b1; exp_out = exp_cur; @(negedge clk);
      chk("R11", "nap cleared by sck rise", int'(nap_a), 0);
      conv = 1'b0; @(negedge clk);
      conv_pulse(14'h0055, 14'h0066);   // sck held high, count becomes 1
      chk("R11", "coincident pulse not counted", int'(nap_a), 0);
      conv_pulse(14'h0077, 14'h0088);
      conv_pulse(14'h0099, 14'h00AA);
      chk("R9", "nap after three pulses", int'(nap_a), 1);
      conv_pulse(14'h00BB, 14'h00CC);
      chk("R10", "sleep after four", int'(slp_a), 1);
      chk("R10", "nap cleared in sleep", int'(nap_a), 0);
      conv_pulse(14'h00DD, 14'h00EE);
      chk("R10", "sleep after five", int'(slp_a), 1);
      sck_fall();
      chk("R11", "sleep cleared by sck fall", int'(slp_a), 0);
      chk("R11", "nap after wake", int'(nap_a), 0);
   endtask

   initial begin
      exp_cur[0] = '0; exp_cur[1] = '0; exp_out = exp_cur;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frames();
      t_late_conv();
      t_power();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule